// File: doc/BRIEF.md
# Burst Serial Port with Byte Buffer

This block is a synchronous serial port that shifts 8-bit bytes through a small buffer of eight byte entries. The host fills the buffer over a simple register bus, chooses how many bytes a burst covers (one to eight), chooses clock master or clock slave operation, and then writes a single start command. The port then exchanges the whole burst on its own. Each outgoing byte leaves the buffer while the byte received in its place overwrites the same entry, so one burst is a full-duplex exchange.

In master operation the port generates the serial clock itself, with a period of 16 system cycles, and the clock rests high between bursts. In slave operation the serial clock comes from outside and is synchronized into the system clock domain. A chip-select option for slave operation drives the data output only while the active-low select pin is low. Deselecting in the middle of a byte aborts the burst and raises an error flag.

Top module: `sio_burst_port`

## Requirements
- R1: Register map on `host_addr`: 0 to 7 read and write the buffer entries; 8 is the control register (bits 2:0 = byte count minus one, bit 3 = master, bit 4 = chip-select gating); a write to 9 is the start command; 10 reads status (bit 0 busy, bit 1 done, bit 2 error). Reads return on `host_rdata` one cycle after the address is presented.
- R2: One start command exchanges exactly count bytes, entries 0 to count-1 in order, with no further host action; entries at or above count are left unchanged.
- R3: In master mode `sck_oe` is 1, the clock goes low on the edge that accepts the start, stays low 8 cycles and high 8 cycles per bit, and rests high when no burst runs.
- R4: Bytes go out MSB first. The first bit appears on `sdo` with the start; each later bit appears when the serial clock falls.
- R5: `sdi` is sampled on each rising serial clock edge, MSB first; each completed byte is written into the entry it was sent from.
- R6: Done is set together with the last rising clock edge of the final byte, while busy clears; a start command clears done and error.
- R7: While busy, further start commands and host writes to the buffer or control register are ignored.
- R8: In slave mode `sck_oe` is 0 and bits move on the synchronized edges of `sck_i` with the same polarity as master mode.
- R9: With chip-select gating in slave mode, `sdo_oe` is 0 while `cs_n` is high and serial clock edges are ignored then; after `cs_n` falls, `sdo_oe` rises within a few system cycles.
- R10: A rising `cs_n` while busy with part of a byte shifted aborts the burst: busy clears, error sets, done stays 0 and the bit counter resets, so the next burst starts at bit 7 of its first byte.
- R11: After reset: `sck_o` = 1, `sck_oe` = 0, `sdo` = 0, `sdo_oe` = 1 and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| cs_n | input | 1 | Active-low chip select |

## Verification
The bench targets the burst length boundaries of one and eight bytes; a design with an off-by-one count either stops a byte short or overwrites the entry just above the burst. It issues a second start, a control write and a buffer write in the middle of a master burst, each of which, if accepted, would restart the clock, cut the burst short or change the transmitted bits that the per-cycle model compares. It toggles the slave clock while deselected, which a design lacking the gate would count as bits, and it aborts a half-shifted byte and then runs a new burst, which exposes a bit counter that is not cleared by showing a misaligned received byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // register offsets above the buffer window
  localparam int OFS_CTRL = 0;
  localparam int OFS_GO   = 1;
  localparam int OFS_STAT = 2;
  localparam int NUM_REGS = 3;

  typedef struct packed {
    logic err;
    logic done;
    logic busy;
  } stat_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int HALF = 8,
  localparam int CW = $clog2(2 * HALF)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic stop,
  output logic sck,
  output logic rise_t,
  output logic fall_t
);
  logic [CW-1:0] cnt;
  logic          act;

  assign rise_t = act && (cnt == CW'(HALF - 1));
  assign fall_t = act && (cnt == CW'(2 * HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
      sck <= 1'b1;
    end else if (go) begin
      act <= 1'b1;
      cnt <= '0;
      sck <= 1'b0;
    end else if (stop) begin
      act <= 1'b0;
      cnt <= '0;
      sck <= 1'b1;
    end else if (act) begin
      cnt <= fall_t ? '0 : cnt + 1'b1;
      if (rise_t) sck <= 1'b1;
      if (fall_t) sck <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_buf.sv
module sio_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra,
  output logic [DW-1:0] rda,
  input  logic [IW-1:0] rb,
  output logic [DW-1:0] rdb
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rda = mem[ra];
  assign rdb = mem[rb];
endmodule

// File: rtl/sio_burst_port.sv
module sio_burst_port
  import sio_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int HALF  = 8,
  parameter int SYNC  = 2,
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = $clog2(DEPTH + NUM_REGS),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          cs_n
);
  // control and state
  logic [IW-1:0] last_q;
  logic          master_q, cs_on_q;
  logic          busy_q, done_q, err_q;
  logic [IW-1:0] idx_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          sdo_q, sdo_oe_q, sck_oe_q;
  logic [DW-1:0] rdata_q;

  // host decode
  logic hit_buf, a_ctrl, a_go, a_stat;
  assign hit_buf = int'(host_addr) < DEPTH;
  assign a_ctrl  = host_addr == AW'(DEPTH + OFS_CTRL);
  assign a_go    = host_addr == AW'(DEPTH + OFS_GO);
  assign a_stat  = host_addr == AW'(DEPTH + OFS_STAT);

  logic start;
  assign start = host_we && a_go && !busy_q;

  // pin synchronizers for slave operation
  logic sck_q, sck_d, cs_q, cs_d, sdi_q;
  sio_sync #(.STAGES(SYNC), .INIT(1'b1)) u_sync_sck (.clk(clk), .rst(rst), .d(sck_i), .q(sck_q));
  sio_sync #(.STAGES(SYNC), .INIT(1'b1)) u_sync_cs  (.clk(clk), .rst(rst), .d(cs_n),  .q(cs_q));
  sio_sync #(.STAGES(SYNC), .INIT(1'b0)) u_sync_sdi (.clk(clk), .rst(rst), .d(sdi),   .q(sdi_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b1;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_q;
      cs_d  <= cs_q;
    end
  end

  logic sel_q, cs_rise, s_rise, s_fall, accept;
  assign sel_q   = ~cs_q;
  assign cs_rise = cs_q & ~cs_d;
  assign s_rise  = sck_q & ~sck_d;
  assign s_fall  = ~sck_q & sck_d;
  assign accept  = !cs_on_q || sel_q;

  // master clock generator
  logic m_rise, m_fall, finish;
  sio_clkgen #(.HALF(HALF)) u_clkgen (
    .clk(clk), .rst(rst), .go(start && master_q), .stop(finish),
    .sck(sck_o), .rise_t(m_rise), .fall_t(m_fall)
  );

  // shift events
  logic rise_ev, fall_ev, sdi_v, abort, byte_end;
  logic [DW-1:0] sh_n;
  assign rise_ev  = busy_q && (master_q ? m_rise : (s_rise && accept));
  assign fall_ev  = busy_q && (master_q ? m_fall : (s_fall && accept));
  assign sdi_v    = master_q ? sdi : sdi_q;
  assign sh_n     = {sh_q[DW-2:0], sdi_v};
  assign byte_end = rise_ev && (bit_q == BW'(DW - 1));
  assign finish   = byte_end && (idx_q == last_q);
  assign abort    = busy_q && !master_q && cs_on_q && cs_rise && (bit_q != '0);

  // buffer with one shared write port
  logic          buf_we;
  logic [IW-1:0] buf_wa, buf_rb;
  logic [DW-1:0] buf_wd, buf_rda, buf_rdb;
  assign buf_we = byte_end || (host_we && hit_buf && !busy_q);
  assign buf_wa = byte_end ? idx_q : host_addr[IW-1:0];
  assign buf_wd = byte_end ? sh_n : host_wdata;
  assign buf_rb = busy_q ? idx_q + 1'b1 : '0;

  sio_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_wa), .wdata(buf_wd),
    .ra(host_addr[IW-1:0]), .rda(buf_rda), .rb(buf_rb), .rdb(buf_rdb)
  );

  // burst sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      master_q <= 1'b0;
      cs_on_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      sdo_q    <= 1'b0;
    end else begin
      if (host_we && a_ctrl && !busy_q) begin
        last_q   <= host_wdata[IW-1:0];
        master_q <= host_wdata[IW];
        cs_on_q  <= host_wdata[IW+1];
      end
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        idx_q  <= '0;
        bit_q  <= '0;
        sh_q   <= buf_rdb;
        sdo_q  <= buf_rdb[DW-1];
      end else if (abort) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
        bit_q  <= '0;
      end else begin
        if (rise_ev) begin
          bit_q <= bit_q + 1'b1;
          if (byte_end) begin
            if (finish) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= buf_rdb;
            end
          end else begin
            sh_q <= sh_n;
          end
        end
        if (fall_ev) sdo_q <= sh_q[DW-1];
      end
    end
  end

  // registered pin enables and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe_q <= 1'b1;
      sck_oe_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      sdo_oe_q <= master_q || !cs_on_q || sel_q;
      sck_oe_q <= master_q;
      if (hit_buf)     rdata_q <= buf_rda;
      else if (a_ctrl) rdata_q <= DW'({cs_on_q, master_q, last_q});
      else if (a_stat) rdata_q <= DW'(stat_t'{err: err_q, done: done_q, busy: busy_q});
      else             rdata_q <= '0;
    end
  end

  assign host_rdata = rdata_q;
  assign sdo        = sdo_q;
  assign sdo_oe     = sdo_oe_q;
  assign sck_oe     = sck_oe_q;
endmodule

// File: rtl/sio_burst_port_chk.sv
module sio_burst_port_chk #(
  parameter int HALF = 8
) (
  input logic clk,
  input logic rst,
  input logic sck_o,
  input logic sck_oe,
  input logic sdo,
  input logic sdo_oe,
  input logic busy,
  input logic done,
  input logic err,
  input logic sel,
  input logic cs_on,
  input logic master
);
  logic [7:0] lowc;

  always_ff @(posedge clk) begin
    if (rst || !sck_oe || sck_o) lowc <= '0;
    else if (lowc != 8'hFF)      lowc <= lowc + 1'b1;
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (sck_oe && !busy) |-> sck_o);

  assert_sck_low_len_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sck_o) && sck_oe) |-> (lowc == 8'(HALF)));

  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (sck_oe && $past(sck_oe) && !$stable(sdo)) |-> $fell(sck_o));

  assert_oe_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cs_on && !master && !sel) |-> !sdo_oe);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_burst_end_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || err));

  assert_abort_flag_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && !busy));
endmodule

bind sio_burst_port sio_burst_port_chk #(.HALF(HALF)) chk_i (
  .clk(clk), .rst(rst), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo),
  .sdo_oe(sdo_oe), .busy(busy_q), .done(done_q), .err(err_q),
  .sel(sel_q), .cs_on(cs_on_q), .master(master_q)
);

// File: tb/sio_burst_port_tb.sv
`timescale 1ns/1ps
module sio_burst_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sck_i = 1'b1;
  logic       sck_o, sck_oe;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe;
  logic       cs_n = 1'b1;

  always #2 clk = ~clk;

  sio_burst_port dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .cs_n(cs_n)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string r, input int a, input int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a[3:0]; host_wdata = d[7:0];
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    host_addr = a[3:0];
    @(negedge clk);
    d = int'(host_rdata);
  endtask

  // behavioural model of a master burst, compared every cycle
  logic [7:0] m_tx [8];
  logic [7:0] m_rx [8];
  int m_n = 1;
  int m_k = 0;
  bit m_run = 0;

  function automatic int kend();
    return 16 * (8 * m_n - 1) + 8;
  endfunction

  always @(negedge clk) begin
    if (m_run) begin
      int b;
      int es;
      b  = (m_k < kend()) ? m_k / 16 : 8 * m_n - 1;
      es = (m_k < kend()) ? int'((m_k % 16) >= 8) : 1;
      chk("R3 sck_o", int'(sck_o), es);
      chk("R4 sdo", int'(sdo), int'(m_tx[b / 8][7 - b % 8]));
      if (m_k / 16 < 8 * m_n) sdi = m_rx[(m_k / 16) / 8][7 - (m_k / 16) % 8];
      else                    sdi = 1'b0;
      m_k++;
      if (m_k > kend() + 4) m_run = 0;
    end
  end

  task automatic start_master();
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'd9;
    @(posedge clk);
    #1;
    host_we = 1'b0;
    m_k = 0;
    m_run = 1;
  endtask

  task automatic run_master(input int n);
    int v;
    m_n = n;
    for (int i = 0; i < n; i++) wr(i, int'(m_tx[i]));
    wr(8, 8 | (n - 1));
    start_master();
    wait (!m_run);
    rd(10, v); chk("R6 done status", v, 2);
    for (int i = 0; i < n; i++) begin
      rd(i, v); chk("R5 rx entry", v, int'(m_rx[i]));
    end
  endtask

  task automatic sbits(input logic [7:0] rxv, input int nb, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sck_i = 1'b0; sdi = rxv[7 - i];
      repeat (8) @(negedge clk);
      got[7 - i] = sdo;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int v;
    logic [7:0] g;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 sck_o", int'(sck_o), 1);
    chk("R11 sck_oe", int'(sck_oe), 0);
    chk("R11 sdo", int'(sdo), 0);
    chk("R11 sdo_oe", int'(sdo_oe), 1);
    rd(10, v); chk("R11 status", v, 0);

    // R1 register read-back
    wr(3, 8'h5C); rd(3, v); chk("R1 buffer readback", v, 8'h5C);
    wr(8, 8'h0B); rd(8, v); chk("R1 ctrl readback", v, 8'h0B);

    // single byte master burst, R2 boundary: entry 1 untouched
    wr(1, 8'h77);
    m_tx[0] = 8'hA5; m_rx[0] = 8'h3C;
    run_master(1);
    rd(1, v); chk("R2 entry above count", v, 8'h77);
    chk("R3 sck_oe master", int'(sck_oe), 1);

    // full eight byte burst
    for (int i = 0; i < 8; i++) begin
      m_tx[i] = 8'(i * 37 + 11);
      m_rx[i] = 8'(i * 53 + 200);
    end
    run_master(8);

    // R7 ignored actions in the middle of a burst
    m_tx[0] = 8'h81; m_tx[1] = 8'h42; m_tx[2] = 8'h18;
    m_rx[0] = 8'hF0; m_rx[1] = 8'h0F; m_rx[2] = 8'h99;
    m_n = 3;
    for (int i = 0; i < 3; i++) wr(i, int'(m_tx[i]));
    wr(8, 8 | 2);
    start_master();
    wait (m_k >= 20);
    wr(1, 8'h00);
    wr(8, 0);
    wr(9, 0);
    rd(10, v); chk("R7 busy during burst", v, 1);
    wait (!m_run);
    rd(8, v); chk("R7 ctrl unchanged", v, 8 | 2);
    rd(1, v); chk("R7 entry from burst", v, 8'h0F);
    rd(10, v); chk("R6 done", v, 2);

    // R8 slave burst of two bytes without gating
    wr(0, 8'hC3); wr(1, 8'h5A);
    wr(8, 1);
    wr(9, 0);
    @(negedge clk);
    chk("R8 sck_oe slave", int'(sck_oe), 0);
    sbits(8'h96, 8, g); chk("R8 slave tx byte0", int'(g), 8'hC3);
    sbits(8'h21, 8, g); chk("R8 slave tx byte1", int'(g), 8'h5A);
    repeat (6) @(negedge clk);
    rd(10, v); chk("R6 slave done", v, 2);
    rd(0, v); chk("R5 slave rx0", v, 8'h96);
    rd(1, v); chk("R5 slave rx1", v, 8'h21);

    // R9 chip-select gating
    wr(0, 8'hE7);
    wr(8, 16);
    wr(9, 0);
    repeat (6) @(negedge clk);
    chk("R9 sdo_oe deselected", int'(sdo_oe), 0);
    sbits(8'hFF, 8, g);
    rd(10, v); chk("R9 edges ignored while deselected", v, 1);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 sdo_oe selected", int'(sdo_oe), 1);

    // R10 abort mid-byte
    sbits(8'h00, 3, g);
    @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    rd(10, v); chk("R10 abort status", v, 4);
    chk("R9 sdo_oe after deselect", int'(sdo_oe), 0);

    // R10 bit counter restarts, R6 start clears error
    wr(0, 8'h6D);
    wr(9, 0);
    rd(10, v); chk("R6 start clears error", v, 1);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    sbits(8'hB4, 8, g); chk("R10 tx after abort", int'(g), 8'h6D);
    repeat (6) @(negedge clk);
    rd(10, v); chk("R10 done after restart", v, 2);
    rd(0, v); chk("R10 rx aligned after abort", v, 8'hB4);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    summary();
  end
endmodule